// File: doc/BRIEF.md
# DRAM-side performance counter unit

This block counts traffic events at the boundary of a DRAM controller. It has a small bank of counters. Counter 0 is the sampling timer and counts clock cycles no matter how it is configured. Each of the other counters has an event-select register that chooses what it counts: cycles, all read-address handshakes, all write-address handshakes, or read/write handshakes whose transaction ID passes a masked compare. A single ID/mask filter register is shared by every counter that uses an ID-match event.

Software starts a measurement by setting the run bit and the clear bit in the same write. When the timer rolls over, every counter stops at the value it holds and an interrupt line rises. Software can then read the counters through a simple synchronous register port. When one of the event counters rolls over, it just wraps and goes on counting, with no side effect. A write-one-to-clear status bit drops the interrupt. The clear bit zeroes all counters and lifts the freeze.

Top module: `dram_perf_monitor`

## Requirements
- R1: After reset, every readable register (control, the four event selects, the filter and the four counters) reads zero and `irq` is low.
- R2: While the run bit (control bit 0) is set and the unit is not frozen, counter 0 increases by one on every clock edge, whatever its event-select value.
- R3: On counters 1 to 3, event code 0x01 counts clock cycles, 0x02 counts read-address handshakes and 0x03 counts write-address handshakes. A handshake is a cycle with both valid and ready high, and a counter steps by at most one per clock.
- R4: Code 0x41 counts read handshakes and code 0x42 counts write handshakes whose ID satisfies ((id XOR filter_id) AND filter_mask) == 0. A mask bit of 1 compares that ID bit. The filter register holds filter_id in bits 15:0 and filter_mask in bits 31:16.
- R5: Any other event code, including 0x00 and 0x7F, selects no event, and the counter holds its value.
- R6: While the run bit is clear, no counter changes, even when handshakes occur.
- R7: Counters 1 to 3 wrap modulo 2^CNT_W on overflow, keep counting, and leave `irq` and the status bit unchanged.
- R8: When counter 0 steps from all ones, it becomes zero and every counter freezes. The frozen flag (control bit 2) and the status bit (control bit 4) are set, and `irq` goes high. Counters 1 to 3 still take the event of that same cycle.
- R9: Writing 1 to control bit 4 clears the status bit and `irq` but leaves the freeze in place. Writing 1 to control bit 1 zeroes all counters and releases the freeze on that edge, and the bit reads back 0.
- R10: Register word addresses are 0 control, 1–4 event selects of counters 0–3, 5 filter, 6–9 counter values (read-only; writes ignored). Read data appears on `reg_rdata` one clock after `reg_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read transaction ID |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write transaction ID |
| irq | output | 1 | Timer expiry interrupt |

## Verification
The bench checks the ID filter with partial masks, an all-zero mask and a top-bit-only mask. A filter that compared unmasked bits, or inverted the mask polarity, would give wrong read and write counts. It also drives a valid without ready, which a design that ignored ready would count. The bench lets the timer expire and reads the counters again later: a cycle counter that kept running after the freeze, or a status clear that also lifted the freeze, shows up as a changed value. An event counter is driven through its own wrap to catch a design that raises the interrupt on any overflow. Run-disabled handshakes and unknown codes are checked to leave counters untouched.

// File: rtl/dpm_pkg.sv
// Shared constants and types for the DRAM performance counter unit.
// Assumes one event-select width for every counter.
package dpm_pkg;
    localparam int EV_W = 8;

    typedef enum logic [EV_W-1:0] {
        EV_NONE   = 8'h00,
        EV_CYCLES = 8'h01,
        EV_RD_ALL = 8'h02,
        EV_WR_ALL = 8'h03,
        EV_RD_ID  = 8'h41,
        EV_WR_ID  = 8'h42
    } ev_code_e;

    localparam int CTRL_RUN_BIT    = 0;
    localparam int CTRL_CLR_BIT    = 1;
    localparam int CTRL_FROZEN_BIT = 2;
    localparam int CTRL_STAT_BIT   = 4;

    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_CFG_BASE = 1;

    // Per-cycle bus activity seen by every event selector
    typedef struct packed {
        logic rd_fire;
        logic wr_fire;
        logic rd_hit;
        logic wr_hit;
    } bus_ev_t;
endpackage

// File: rtl/dpm_id_filter.sv
// Detects an address-channel handshake and applies the masked ID compare.
// Assumes mask bit 1 means "compare this bit".
module dpm_id_filter #(
    parameter int ID_W = 16
) (
    input  logic            valid,
    input  logic            ready,
    input  logic [ID_W-1:0] id,
    input  logic [ID_W-1:0] match_id,
    input  logic [ID_W-1:0] match_mask,
    output logic            fire,
    output logic            pass
);
    // Handshake and masked compare, purely combinational
    always_comb begin
        fire = valid & ready;
        pass = ((id ^ match_id) & match_mask) == '0;
    end
endmodule

// File: rtl/dpm_event_sel.sv
// Maps an event code onto the bus activity of this cycle.
// Unknown codes select nothing.
module dpm_event_sel
    import dpm_pkg::*;
(
    input  logic [EV_W-1:0] code,
    input  bus_ev_t         bus,
    output logic            hit
);
    // Event decode
    always_comb begin
        case (code)
            EV_CYCLES: hit = 1'b1;
            EV_RD_ALL: hit = bus.rd_fire;
            EV_WR_ALL: hit = bus.wr_fire;
            EV_RD_ID:  hit = bus.rd_fire & bus.rd_hit;
            EV_WR_ID:  hit = bus.wr_fire & bus.wr_hit;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dpm_counter.sv
// Plain wrapping counter with synchronous clear taking priority over increment.
module dpm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    // Count state update
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (inc) q <= q + 1'b1;
    end
endmodule

// File: rtl/dpm_regs.sv
// Register file: control, event selects, shared filter, read-only counters.
// Assumes 2*ID_W <= DATA_W and counters no wider than DATA_W.
module dpm_regs
    import dpm_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int TIMER_W = 32,
    parameter int CNT_W   = 32,
    parameter int ID_W    = 16,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    input  logic [TIMER_W-1:0]           timer_q,
    input  logic [(NUM_CNT-1)*CNT_W-1:0] evc_flat,
    input  logic                         frozen,
    input  logic                         expire,
    output logic                         run,
    output logic                         clr_pulse,
    output logic                         status,
    output logic [NUM_CNT*EV_W-1:0]      evsel_flat,
    output logic [ID_W-1:0]              filt_id,
    output logic [ID_W-1:0]              filt_mask
);
    localparam int FILT_ADDR = ADDR_CFG_BASE + NUM_CNT;
    localparam int CNT_BASE  = FILT_ADDR + 1;

    logic              wr_ctrl;
    logic [EV_W-1:0]   evsel_q [NUM_CNT];
    logic [DATA_W-1:0] rd_mux;

    assign wr_ctrl   = wr_en && (addr == ADDR_W'(ADDR_CTRL));
    assign clr_pulse = wr_ctrl && wdata[CTRL_CLR_BIT];

    // Run bit
    always_ff @(posedge clk) begin
        if (!rst_n)       run <= 1'b0;
        else if (wr_ctrl) run <= wdata[CTRL_RUN_BIT];
    end

    // Expiry status: set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)                              status <= 1'b0;
        else if (expire)                         status <= 1'b1;
        else if (wr_ctrl && wdata[CTRL_STAT_BIT]) status <= 1'b0;
    end

    // Shared ID filter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_id   <= '0;
            filt_mask <= '0;
        end else if (wr_en && addr == ADDR_W'(FILT_ADDR)) begin
            filt_id   <= wdata[ID_W-1:0];
            filt_mask <= wdata[2*ID_W-1:ID_W];
        end
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_evsel
        // Event select register of counter k
        always_ff @(posedge clk) begin
            if (!rst_n) evsel_q[k] <= '0;
            else if (wr_en && addr == ADDR_W'(ADDR_CFG_BASE + k)) evsel_q[k] <= wdata[EV_W-1:0];
        end
        assign evsel_flat[k*EV_W +: EV_W] = evsel_q[k];
    end

    // Read data selection
    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(ADDR_CTRL)) begin
            rd_mux[CTRL_RUN_BIT]    = run;
            rd_mux[CTRL_FROZEN_BIT] = frozen;
            rd_mux[CTRL_STAT_BIT]   = status;
        end
        if (addr == ADDR_W'(FILT_ADDR)) rd_mux = DATA_W'({filt_mask, filt_id});
        if (addr == ADDR_W'(CNT_BASE))  rd_mux = DATA_W'(timer_q);
        for (int k = 0; k < NUM_CNT; k++) begin
            if (addr == ADDR_W'(ADDR_CFG_BASE + k)) rd_mux = DATA_W'(evsel_q[k]);
        end
        for (int k = 1; k < NUM_CNT; k++) begin
            if (addr == ADDR_W'(CNT_BASE + k)) rd_mux = DATA_W'(evc_flat[(k-1)*CNT_W +: CNT_W]);
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/dram_perf_monitor.sv
// Top of the DRAM performance counter unit. Counter 0 is a free-running
// timer whose rollover freezes the bank and raises irq; counters 1..NUM_CNT-1
// count selected bus events and wrap silently.
// Assumes NUM_CNT >= 2 and the register map fits in ADDR_W bits.
module dram_perf_monitor
    import dpm_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int TIMER_W = 32,
    parameter int CNT_W   = 32,
    parameter int ID_W    = 16,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ar_valid,
    input  logic              ar_ready,
    input  logic [ID_W-1:0]   ar_id,
    input  logic              aw_valid,
    input  logic              aw_ready,
    input  logic [ID_W-1:0]   aw_id,
    output logic              irq
);
    localparam int NUM_EV = NUM_CNT - 1;

    logic                      run;
    logic                      clr_pulse;
    logic                      status;
    logic                      frozen_q;
    logic                      count_en;
    logic                      expire;
    logic [TIMER_W-1:0]        timer_q;
    logic [NUM_EV*CNT_W-1:0]   evc_flat;
    logic [NUM_CNT*EV_W-1:0]   evsel_flat;
    logic [ID_W-1:0]           filt_id;
    logic [ID_W-1:0]           filt_mask;
    bus_ev_t                   bus;

    dpm_regs #(
        .NUM_CNT(NUM_CNT), .TIMER_W(TIMER_W), .CNT_W(CNT_W),
        .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .timer_q(timer_q), .evc_flat(evc_flat),
        .frozen(frozen_q), .expire(expire),
        .run(run), .clr_pulse(clr_pulse), .status(status),
        .evsel_flat(evsel_flat), .filt_id(filt_id), .filt_mask(filt_mask)
    );

    dpm_id_filter #(.ID_W(ID_W)) u_rd_filter (
        .valid(ar_valid), .ready(ar_ready), .id(ar_id),
        .match_id(filt_id), .match_mask(filt_mask),
        .fire(bus.rd_fire), .pass(bus.rd_hit)
    );

    dpm_id_filter #(.ID_W(ID_W)) u_wr_filter (
        .valid(aw_valid), .ready(aw_ready), .id(aw_id),
        .match_id(filt_id), .match_mask(filt_mask),
        .fire(bus.wr_fire), .pass(bus.wr_hit)
    );

    assign count_en = run & ~frozen_q;
    assign expire   = count_en & (&timer_q) & ~clr_pulse;
    assign irq      = status;

    // Timer: counter 0, ignores its event select
    dpm_counter #(.W(TIMER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .inc(count_en), .q(timer_q)
    );

    // Freeze flag: set on timer rollover, released by clear
    always_ff @(posedge clk) begin
        if (!rst_n)         frozen_q <= 1'b0;
        else if (clr_pulse) frozen_q <= 1'b0;
        else if (expire)    frozen_q <= 1'b1;
    end

    for (genvar k = 1; k < NUM_CNT; k++) begin : g_evc
        logic hit;

        dpm_event_sel u_sel (
            .code(evsel_flat[k*EV_W +: EV_W]), .bus(bus), .hit(hit)
        );

        dpm_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr_pulse),
            .inc(count_en & hit), .q(evc_flat[(k-1)*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/dpm_checker.sv
// Temporal checks on the counter bank, bound into the top module.
module dpm_checker #(
    parameter int TIMER_W = 32,
    parameter int CNT_W   = 32,
    parameter int NUM_EV  = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    irq,
    input logic                    run,
    input logic                    frozen_q,
    input logic                    clr_pulse,
    input logic [TIMER_W-1:0]      timer_q,
    input logic [NUM_EV*CNT_W-1:0] evc_flat
);
    // R8: a frozen bank holds every counter
    assert_freeze_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_q && $past(frozen_q)) |-> ($stable(timer_q) && $stable(evc_flat)));

    // R8: interrupt rises only with a timer rollover
    assert_irq_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (timer_q == '0 && $past(timer_q) == '1));

    // R6: stopped counters hold
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!run) && !$past(clr_pulse)) |-> ($stable(timer_q) && $stable(evc_flat)));

    // R9: clear zeroes every counter
    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_pulse) |-> (timer_q == '0 && evc_flat == '0 && !frozen_q));

    // R2: timer moves by at most one per edge
    assert_timer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_pulse) |-> (timer_q == $past(timer_q) || timer_q == TIMER_W'($past(timer_q) + 1'b1)));

    for (genvar k = 0; k < NUM_EV; k++) begin : g_step
        // R3: event counters step by at most one per edge
        assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(clr_pulse) |->
                (evc_flat[k*CNT_W +: CNT_W] == $past(evc_flat[k*CNT_W +: CNT_W]) ||
                 evc_flat[k*CNT_W +: CNT_W] == CNT_W'($past(evc_flat[k*CNT_W +: CNT_W]) + 1'b1)));
    end
endmodule

bind dram_perf_monitor dpm_checker #(
    .TIMER_W(TIMER_W), .CNT_W(CNT_W), .NUM_EV(NUM_CNT-1)
) u_dpm_checker (
    .clk(clk), .rst_n(rst_n), .irq(irq), .run(run), .frozen_q(frozen_q),
    .clr_pulse(clr_pulse), .timer_q(timer_q), .evc_flat(evc_flat)
);

// File: tb/dram_perf_monitor_bench.sv
`timescale 1ns/1ps
module dram_perf_monitor_bench;
    localparam int CNT_W   = 8;
    localparam int TIMER_W = 10;
    localparam int ID_W    = 16;

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_CFG0 = 4'd1;
    localparam logic [3:0] A_FILT = 4'd5;
    localparam logic [3:0] A_CNT0 = 4'd6;

    // {code3, fid, mask, rid, wid, nrd, nwr, exp1, exp2, exp3}
    localparam logic [111:0] VEC [6] = '{
        {8'h02, 16'h0012, 16'hFFFF, 16'h0012, 16'h0013, 8'd5, 8'd3, 8'd5, 8'd0, 8'd5},
        {8'h03, 16'h0010, 16'hFFF0, 16'h001F, 16'h0013, 8'd4, 8'd6, 8'd4, 8'd6, 8'd6},
        {8'h00, 16'hABCD, 16'h0000, 16'h1234, 16'h5678, 8'd2, 8'd7, 8'd2, 8'd7, 8'd0},
        {8'h7F, 16'h00FF, 16'h00F0, 16'h00F1, 16'h010F, 8'd3, 8'd3, 8'd3, 8'd0, 8'd0},
        {8'h41, 16'h8000, 16'h8000, 16'h7FFF, 16'hFFFF, 8'd6, 8'd2, 8'd0, 8'd2, 8'd0},
        {8'h02, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr_en = 1'b0;
    logic            reg_rd_en = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            ar_valid = 1'b0, ar_ready = 1'b0;
    logic [ID_W-1:0] ar_id = '0;
    logic            aw_valid = 1'b0, aw_ready = 1'b0;
    logic [ID_W-1:0] aw_id = '0;
    logic            irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dram_perf_monitor #(.CNT_W(CNT_W), .TIMER_W(TIMER_W)) u_dram_perf_monitor (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic drive_bus(input int nrd, input int nwr, input logic [15:0] rid, input logic [15:0] wid);
        int n;
        n = (nrd > nwr) ? nrd : nwr;
        // stalled handshakes and ready without valid: none may count
        @(negedge clk);
        ar_valid = 1'b1; ar_ready = 1'b0; aw_valid = 1'b1; aw_ready = 1'b0;
        ar_id = rid; aw_id = wid;
        @(negedge clk);
        ar_valid = 1'b0; ar_ready = 1'b1; aw_valid = 1'b0; aw_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ar_valid = (i < nrd); ar_ready = 1'b1; ar_id = rid;
            aw_valid = (i < nwr); aw_ready = 1'b1; aw_id = wid;
        end
        @(negedge clk);
        ar_valid = 1'b0; aw_valid = 1'b0; ar_ready = 1'b0; aw_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] c0_before;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check("R1 irq", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 10; a++) begin
            reg_read(4'(a), d);
            check("R1 reg", d, 32'd0);
        end

        // Vector table: R3, R4, R5, R10
        for (int v = 0; v < 6; v++) begin
            reg_write(A_CFG0, 32'h00);
            reg_write(A_CFG0 + 4'd1, 32'h41);
            reg_write(A_CFG0 + 4'd2, 32'h42);
            reg_write(A_CFG0 + 4'd3, {24'd0, VEC[v][111:104]});
            reg_write(A_FILT, {VEC[v][87:72], VEC[v][103:88]});
            reg_read(A_FILT, d);
            check("R10 filter readback", d, {VEC[v][87:72], VEC[v][103:88]});
            reg_read(A_CFG0 + 4'd3, d);
            check("R10 select readback", d, {24'd0, VEC[v][111:104]});
            reg_write(A_CTRL, 32'h3);
            drive_bus(int'(VEC[v][39:32]), int'(VEC[v][31:24]), VEC[v][71:56], VEC[v][55:40]);
            reg_write(A_CTRL, 32'h0);
            reg_read(A_CNT0 + 4'd1, d);
            check("R4 id read count", d, {24'd0, VEC[v][23:16]});
            reg_read(A_CNT0 + 4'd2, d);
            check("R4 id write count", d, {24'd0, VEC[v][15:8]});
            reg_read(A_CNT0 + 4'd3, d);
            check("R3/R5 selected count", d, {24'd0, VEC[v][7:0]});
        end

        // R6: stopped unit ignores handshakes
        reg_read(A_CNT0, c0_before);
        drive_bus(4, 4, 16'h0, 16'h0);
        reg_read(A_CNT0 + 4'd1, d);
        check("R6 held id-read counter", d, 32'd0);
        reg_read(A_CNT0 + 4'd3, d);
        check("R6 held read counter", d, 32'd0);
        reg_read(A_CNT0, d);
        check("R6 held timer", d, c0_before);

        // R2 and R7: timer with code 0 counts; counter1 counting cycles wraps
        reg_write(A_CFG0, 32'h00);
        reg_write(A_CFG0 + 4'd1, 32'h01);
        reg_write(A_CTRL, 32'h3);
        repeat (298) @(negedge clk);
        reg_write(A_CTRL, 32'h0);
        reg_read(A_CNT0, d);
        check("R2 timer cycles", d, 32'd300);
        reg_read(A_CNT0 + 4'd1, d);
        check("R7 wrapped counter", d, 32'd44);
        check("R7 no irq", {31'd0, irq}, 32'd0);
        reg_read(A_CTRL, d);
        check("R7 status clear", d, 32'd0);
        reg_write(A_CNT0, 32'hFFFF_FFFF);
        reg_read(A_CNT0, d);
        check("R10 counter read-only", d, 32'd300);

        // R8: timer expiry freezes the bank
        reg_write(A_CFG0 + 4'd2, 32'h00);
        reg_write(A_CTRL, 32'h3);
        repeat (1100) @(negedge clk);
        check("R8 irq high", {31'd0, irq}, 32'd1);
        reg_read(A_CNT0, d);
        check("R8 timer zero", d, 32'd0);
        reg_read(A_CNT0 + 4'd1, d);
        check("R8 counter1 took last event", d, 32'd0);
        reg_read(A_CTRL, d);
        check("R8 control flags", d, 32'h15);
        repeat (20) @(negedge clk);
        reg_read(A_CNT0 + 4'd1, d);
        check("R8 counter1 frozen", d, 32'd0);
        reg_read(A_CNT0, d);
        check("R8 timer frozen", d, 32'd0);

        // R9: status clear keeps freeze; clear bit releases it
        reg_write(A_CTRL, 32'h11);
        check("R9 irq dropped", {31'd0, irq}, 32'd0);
        reg_read(A_CTRL, d);
        check("R9 still frozen", d, 32'h05);
        repeat (10) @(negedge clk);
        reg_read(A_CNT0 + 4'd1, d);
        check("R9 freeze kept", d, 32'd0);
        reg_write(A_CTRL, 32'h3);
        repeat (5) @(negedge clk);
        reg_write(A_CTRL, 32'h0);
        reg_read(A_CNT0, d);
        check("R9 timer restarted", d, 32'd7);
        reg_read(A_CNT0 + 4'd1, d);
        check("R9 counter restarted", d, 32'd7);
        reg_read(A_CTRL, d);
        check("R9 clear bit reads zero", d, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule